// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block turns the starting column of a DRAM read or write burst into the column addresses that the burst visits, one address per data beat. A start strobe loads the starting column, a three-bit burst-length code and a one-bit ordering select. The block then presents beat 0 and steps to the next beat each time the consumer accepts the current one. Reads and writes share the same generator, because both use the same programmed length and ordering.

The burst stays inside an aligned block of columns whose size equals the burst length. The column bits above that block never change during the burst. The low bits start at the starting column's low bits. In sequential ordering they count upward and wrap at the block boundary. In interleaved ordering they are the starting low bits XORed with the beat index.

The beat output is a valid/ready stream: `valid_o` is the valid and `adv_i` is the ready. A beat transfers on a rising edge where both are high. While `valid_o` is high and `adv_i` is low, the presented beat is held unchanged, so the consumer can apply back-pressure for any number of cycles. The start strobe and the error flag are plain control pins.

Top module: `ddr_burst_colgen`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `err_o` are low.
- R2: A start with a legal length code while idle raises `valid_o` on the next cycle, and beat 0 equals the starting column. The legal codes are 3'b001 for length 2, 3'b010 for length 4 and 3'b011 for length 8.
- R3: With `ileave_i` = 0 (sequential), the low log2(BL) bits of beat k are (start_low + k) mod BL.
- R4: With `ileave_i` = 1 (interleaved), the low log2(BL) bits of beat k are start_low XOR k.
- R5: On every beat, the column bits above bit log2(BL)-1 equal those of the starting column.
- R6: `last_o` is high only on beat BL-1. Once that beat is accepted, `valid_o` is low on the next cycle.
- R7: While `valid_o` is high and `adv_i` is low, `col_o`, `valid_o` and `last_o` hold their values.
- R8: A start strobe while a burst is active is ignored, and the running burst continues unchanged.
- R9: A start with a reserved length code (any code other than 001, 010 and 011) while idle drives `err_o` high for exactly one cycle and produces no beats.
- R10: Changes on `start_col_i`, `bl_code_i` and `ileave_i` during a burst have no effect on its beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| start_col_i | input | COL_W | Starting column address |
| bl_code_i | input | 3 | Burst-length code |
| ileave_i | input | 1 | Ordering select: 0 sequential, 1 interleaved |
| adv_i | input | 1 | Ready: the current beat is accepted |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | The presented beat is the final one |
| err_o | output | 1 | One-cycle pulse after a reserved-code start |

## Verification
The assertions assume that inputs are driven synchronously to `clk` and that `adv_i` is only meaningful while `valid_o` is high. The stimulus changes inputs on the falling edge only. Sequences of stalls and starts are produced only by the directed tasks. Some tasks hold the start strobe high and change the length, ordering and column inputs while a burst runs, so the rules on ignored inputs are exercised without ever breaking the synchronous-drive assumption.

// File: rtl/ddr_colgen_pkg.sv
package ddr_colgen_pkg;
  localparam logic [2:0] BLC_2 = 3'b001;
  localparam logic [2:0] BLC_4 = 3'b010;
  localparam logic [2:0] BLC_8 = 3'b011;
  typedef enum logic {ORD_SEQ = 1'b0, ORD_XOR = 1'b1} order_e;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode #(
  parameter int MAX_LOG = 3
) (
  input  logic [2:0]         code_i,
  output logic               legal_o,
  output logic [MAX_LOG-1:0] mask_o
);
  import ddr_colgen_pkg::*;
  logic [2:0] lg;

  always_comb begin
    case (code_i)
      BLC_2:   lg = 3'd1;
      BLC_4:   lg = 3'd2;
      BLC_8:   lg = 3'd3;
      default: lg = 3'd0;
    endcase
  end

  assign legal_o = (lg != 3'd0) && (int'(lg) <= MAX_LOG);

  for (genvar i = 0; i < MAX_LOG; i++) begin : g_mask
    assign mask_o[i] = legal_o && (int'(lg) > i);
  end
endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         step_i,
  output logic [W-1:0] k_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       k_o <= '0;
    else if (clear_i) k_o <= '0;
    else if (step_i)  k_o <= k_o + 1'b1;
  end
endmodule

// File: rtl/colgen_order.sv
module colgen_order #(
  parameter int COL_W   = 10,
  parameter int MAX_LOG = 3
) (
  input  logic [COL_W-1:0]   base_i,
  input  logic [MAX_LOG-1:0] mask_i,
  input  logic               ileave_i,
  input  logic [MAX_LOG-1:0] k_i,
  output logic [COL_W-1:0]   col_o
);
  logic [MAX_LOG-1:0] low_seq, low_xor, low_sel;

  assign low_seq = base_i[MAX_LOG-1:0] + k_i;
  assign low_xor = base_i[MAX_LOG-1:0] ^ k_i;
  assign low_sel = ileave_i ? low_xor : low_seq;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    if (i < MAX_LOG) begin : g_low
      assign col_o[i] = mask_i[i] ? low_sel[i] : base_i[i];
    end else begin : g_high
      assign col_o[i] = base_i[i];
    end
  end
endmodule

// File: rtl/ddr_burst_colgen.sv
module ddr_burst_colgen #(
  parameter int COL_W   = 10,
  parameter int MAX_LOG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             ileave_i,
  input  logic             adv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);
  logic               active_q, il_q, err_q;
  logic [COL_W-1:0]   base_q;
  logic [MAX_LOG-1:0] mask_q, dec_mask, k;
  logic               dec_legal, accept;

  colgen_len_decode #(.MAX_LOG(MAX_LOG)) u_dec (
    .code_i(bl_code_i), .legal_o(dec_legal), .mask_o(dec_mask)
  );

  assign accept = start_i && !active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      il_q     <= 1'b0;
      err_q    <= 1'b0;
      base_q   <= '0;
      mask_q   <= '0;
    end else begin
      err_q <= accept && !dec_legal;
      if (accept && dec_legal) begin
        active_q <= 1'b1;
        base_q   <= start_col_i;
        mask_q   <= dec_mask;
        il_q     <= ileave_i;
      end else if (active_q && adv_i && last_o) begin
        active_q <= 1'b0;
      end
    end
  end

  colgen_beat_ctr #(.W(MAX_LOG)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear_i(accept),
    .step_i(active_q && adv_i && !last_o), .k_o(k)
  );

  colgen_order #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_ord (
    .base_i(base_q), .mask_i(mask_q), .ileave_i(il_q), .k_i(k), .col_o(col_o)
  );

  assign valid_o = active_q;
  assign last_o  = active_q && (k == mask_q);
  assign err_o   = err_q;

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !adv_i) |=> (valid_o && $stable(col_o) && $stable(last_o)));
  // R6
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && adv_i && last_o) |=> !valid_o);
  // R5
  upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !(adv_i && last_o)) |=> ((col_o >> MAX_LOG) == $past(col_o >> MAX_LOG)));
  // R9
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o);
  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
  // R6
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);
endmodule

// File: tb/ddr_burst_colgen_bench.sv
module ddr_burst_colgen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0] bl_code_i = 3'b000;
  logic ileave_i = 1'b0;
  logic adv_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic valid_o, last_o, err_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_burst_colgen #(.COL_W(COL_W), .MAX_LOG(3)) u_ddr_burst_colgen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .bl_code_i(bl_code_i), .ileave_i(ileave_i), .adv_i(adv_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_col(int s, int lg, bit il, int k);
    int bl = 1 << lg;
    int low = s % bl;
    int nl = il ? (low ^ k) : ((low + k) % bl);
    return (s - low) + nl;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid", int'(valid_o), 0);
    chk(last_o == 1'b0, "R1 last", int'(last_o), 0);
    chk(err_o == 1'b0, "R1 err", int'(err_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // stall: hold adv low for one cycle on each beat; poke: disturb inputs mid-burst
  task automatic run_burst(input int s, input logic [2:0] code, input int lg,
                           input bit il, input bit stall, input bit poke);
    int bl = 1 << lg;
    start_i = 1'b1; start_col_i = COL_W'(s); bl_code_i = code; ileave_i = il; adv_i = 1'b0;
    @(negedge clk);
    if (poke) begin
      start_col_i = ~COL_W'(s); bl_code_i = 3'b001; ileave_i = ~il;
    end else start_i = 1'b0;
    chk(valid_o == 1'b1, "R2 valid after start", int'(valid_o), 1);
    chk(int'(col_o) == s, "R2 first beat", int'(col_o), s);
    for (int k = 0; k < bl; k++) begin
      if (stall) begin
        logic [COL_W-1:0] held = col_o;
        logic hl = last_o;
        adv_i = 1'b0;
        @(negedge clk);
        chk(valid_o && col_o == held && last_o == hl, "R7 hold under stall",
            int'(col_o), int'(held));
      end
      chk(valid_o == 1'b1, "R6 valid mid burst", int'(valid_o), 1);
      chk(int'(col_o) == exp_col(s, lg, il, k),
          il ? (poke ? "R4/R8/R10 xor beat" : "R4 xor beat")
             : (poke ? "R3/R8/R10 seq beat" : "R3 seq beat"),
          int'(col_o), exp_col(s, lg, il, k));
      chk((int'(col_o) >> lg) == (s >> lg), "R5 upper bits", int'(col_o) >> lg, s >> lg);
      chk(last_o == (k == bl - 1), "R6 last flag", int'(last_o), int'(k == bl - 1));
      adv_i = 1'b1;
      @(negedge clk);
    end
    adv_i = 1'b0;
    start_i = 1'b0;
    chk(valid_o == 1'b0, "R6 idle after last", int'(valid_o), 0);
    @(negedge clk);
    chk(valid_o == 1'b0, "R8 no late start", int'(valid_o), 0);
  endtask

  task automatic t_reserved(input logic [2:0] code);
    start_i = 1'b1; bl_code_i = code; start_col_i = 10'h155; adv_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o == 1'b1, "R9 err pulse", int'(err_o), 1);
    chk(valid_o == 1'b0, "R9 no beat", int'(valid_o), 0);
    @(negedge clk);
    chk(err_o == 1'b0, "R9 err one cycle", int'(err_o), 0);
    chk(valid_o == 1'b0, "R9 still no beat", int'(valid_o), 0);
    adv_i = 1'b0;
  endtask

  initial begin
    t_reset();
    run_burst(10'h005, 3'b001, 1, 1'b0, 1'b0, 1'b0);
    run_burst(10'h1F6, 3'b010, 2, 1'b0, 1'b0, 1'b0);
    run_burst(10'h2AD, 3'b011, 3, 1'b0, 1'b0, 1'b0);
    run_burst(10'h0F3, 3'b011, 3, 1'b1, 1'b0, 1'b0);
    run_burst(10'h3FF, 3'b010, 2, 1'b1, 1'b0, 1'b0);
    run_burst(10'h101, 3'b001, 1, 1'b1, 1'b0, 1'b0);
    run_burst(10'h0C6, 3'b011, 3, 1'b0, 1'b1, 1'b0);
    run_burst(10'h21A, 3'b011, 3, 1'b1, 1'b0, 1'b1);
    run_burst(10'h03B, 3'b010, 2, 1'b0, 1'b1, 1'b1);
    t_reserved(3'b000);
    t_reserved(3'b100);
    t_reserved(3'b111);
    run_burst(10'h007, 3'b011, 3, 1'b0, 1'b0, 1'b0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule